// File: doc/BRIEF.md
# Ternary-Logic and Bit-Permute Unit

A purely combinational bit-manipulation datapath working on words of `DATA_W` bits (64 by default). It offers two operations, chosen by a one-bit select. The first is a per-bit three-input logic function. An 8-bit truth table is looked up at every bit position, and the lookup index is built from the matching bits of the three operands.

The second is a generalized bit reverse. Each result bit is taken from the first operand at the position given by its own index XORed with a control value. That control value comes from the low bits of the second operand. A narrow mode restricts the permutation to the lower half of the word and forces the upper half of the result to zero.

The unit has no state and no clock. It is meant to sit inside a larger execution stage that handles decoding and registering. Its carry output is tied low, so it fits a result bus that expects a carry.

Top module: `bitmix_unit`

## Requirements
- R1: With `op_sel` = 0 (ternary), `result[i]` equals `truth_tbl[k]` for every i, where k = {`opnd_c[i]`, `opnd_a[i]`, `opnd_b[i]`} (opnd_c is the MSB, opnd_b the LSB).
- R2: `op_sel` is 1 bit: value 0 selects the ternary function and value 1 selects the bit permute.
- R3: With `op_sel` = 1 and `narrow` = 0, `result[i]` equals `opnd_a[i XOR opnd_b[5:0]]` for all 64 positions.
- R4: With `op_sel` = 1 and `narrow` = 1, `result[i]` equals `opnd_a[i XOR opnd_b[4:0]]` for i < 32. In this mode `opnd_a[63:32]` and `opnd_b[5]` have no effect on the result.
- R5: With `op_sel` = 1 and `narrow` = 1, `result[63:32]` is zero.
- R6: `carry_out` is 0 for every input combination.
- R7: With `op_sel` = 1, `truth_tbl` has no effect on `result`.
- R8: In the permute operation, a control value of zero returns `opnd_a` unchanged. In wide mode, a control value of all ones returns `opnd_a` bit-reversed.
- R9: With `op_sel` = 0, `narrow` has no effect on `result`.
- R10: In the permute operation, `opnd_b` bits above the control field (bits 63:6) have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 1 | 0 = ternary logic, 1 = bit permute |
| narrow | input | 1 | Half-width permute mode |
| opnd_a | input | DATA_W | First operand; source of the permute |
| opnd_b | input | DATA_W | Second operand; its low bits are the permute control |
| opnd_c | input | DATA_W | Third operand (ternary index MSB) |
| truth_tbl | input | 8 | Three-input truth table |
| result | output | DATA_W | Operation result |
| carry_out | output | 1 | Always zero |

## Verification
The bench builds the unit at its default width of 64 bits. At that width the control field is only six bits, so every control value in both modes can be swept. This covers the identity case, the full reversal, and each single-stage swap. All 256 truth tables are swept against several operand patterns, in both settings of the narrow flag. During permute runs, changing truth tables and junk in the upper control bits exercise the inputs that must be ignored.

// File: rtl/bitmix_pkg.sv
package bitmix_pkg;
   typedef enum logic {
      OP_TERN = 1'b0,
      OP_PERM = 1'b1
   } bitmix_op_e;

   localparam int TBL_W = 8;
endpackage

// File: rtl/bitmix_tern.sv
module bitmix_tern #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]            in_x,
   input  logic [DATA_W-1:0]            in_y,
   input  logic [DATA_W-1:0]            in_z,
   input  logic [bitmix_pkg::TBL_W-1:0] tbl,
   output logic [DATA_W-1:0]            dst
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic [2:0] idx;
      assign idx    = {in_z[i], in_x[i], in_y[i]};
      assign dst[i] = tbl[idx];
   end

   always_comb begin
      if (!$isunknown(tbl) && tbl == '0)
         assert_const_low_R1: assert (dst == '0)
            else $error("ternary: all-zero table gave nonzero result");
      if (!$isunknown(tbl) && tbl == '1)
         assert_const_high_R1: assert (dst == '1)
            else $error("ternary: all-one table gave non-ones result");
   end
endmodule

// File: rtl/bitmix_grev.sv
module bitmix_grev #(
   parameter int DATA_W = 64,
   localparam int STAGES = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [STAGES-1:0] ctl,
   output logic [DATA_W-1:0] dst
);
   logic [DATA_W-1:0] lvl [STAGES+1];

   assign lvl[0] = src;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int BLK = 1 << s;
      for (genvar j = 0; j < DATA_W; j++) begin : g_bit
         assign lvl[s+1][j] = ctl[s] ? lvl[s][j ^ BLK] : lvl[s][j];
      end
   end

   assign dst = lvl[STAGES];

   always_comb begin
      if (!$isunknown(ctl) && ctl == '0)
         assert_identity_R8: assert (dst == src)
            else $error("permute: zero control altered source");
      if (!$isunknown(src))
         assert_popcount_R3: assert ($countones(dst) == $countones(src))
            else $error("permute: bit count not preserved");
   end
endmodule

// File: rtl/bitmix_unit.sv
module bitmix_unit #(
   parameter int DATA_W = 64
) (
   input  logic                         op_sel,
   input  logic                         narrow,
   input  logic [DATA_W-1:0]            opnd_a,
   input  logic [DATA_W-1:0]            opnd_b,
   input  logic [DATA_W-1:0]            opnd_c,
   input  logic [bitmix_pkg::TBL_W-1:0] truth_tbl,
   output logic [DATA_W-1:0]            result,
   output logic                         carry_out
);
   import bitmix_pkg::*;

   localparam int STAGES = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W < 4 || (1 << STAGES) != DATA_W) begin : g_bad_width
      $error("bitmix_unit: DATA_W must be a power of two of at least 4");
   end

   logic [DATA_W-1:0] tern_q;
   logic [DATA_W-1:0] perm_q;
   logic [DATA_W-1:0] perm_src;
   logic [STAGES-1:0] perm_ctl;

   bitmix_tern #(.DATA_W(DATA_W)) u_tern (
      .in_x (opnd_a),
      .in_y (opnd_b),
      .in_z (opnd_c),
      .tbl  (truth_tbl),
      .dst  (tern_q)
   );

   always_comb begin
      if (narrow) begin
         perm_src = {{HALF_W{1'b0}}, opnd_a[HALF_W-1:0]};
         perm_ctl = {1'b0, opnd_b[STAGES-2:0]};
      end else begin
         perm_src = opnd_a;
         perm_ctl = opnd_b[STAGES-1:0];
      end
   end

   bitmix_grev #(.DATA_W(DATA_W)) u_grev (
      .src (perm_src),
      .ctl (perm_ctl),
      .dst (perm_q)
   );

   assign result    = (bitmix_op_e'(op_sel) == OP_PERM) ? perm_q : tern_q;
   assign carry_out = 1'b0;

   always_comb begin
      assert_carry_zero_R6: assert (carry_out == 1'b0)
         else $error("carry output raised");
      if (!$isunknown({op_sel, narrow, opnd_a}) && op_sel && narrow)
         assert_upper_zero_R5: assert (result[DATA_W-1:HALF_W] == '0)
            else $error("narrow permute left upper half nonzero");
   end
endmodule

// File: tb/tb_bitmix_unit.sv
module tb_bitmix_unit;
   localparam int W = 64;

   logic          clk = 1'b0;
   logic          op_sel, narrow;
   logic [W-1:0]  opnd_a, opnd_b, opnd_c;
   logic [7:0]    truth_tbl;
   logic [W-1:0]  result;
   logic          carry_out;
   int            n_chk = 0;
   int            n_bad = 0;
   logic          done = 1'b0;

   always #2 clk = ~clk;

   bitmix_unit #(.DATA_W(W)) dut (
      .op_sel, .narrow, .opnd_a, .opnd_b, .opnd_c,
      .truth_tbl, .result, .carry_out
   );

   function automatic logic [W-1:0] exp_tern(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] c, logic [7:0] t);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = t[{c[i], a[i], b[i]}];
      return r;
   endfunction

   function automatic logic [W-1:0] exp_perm(logic [W-1:0] a, logic [W-1:0] b, logic nar);
      logic [W-1:0] r = '0;
      if (nar) for (int i = 0; i < 32; i++) r[i] = a[i ^ int'(b[4:0])];
      else     for (int i = 0; i < W; i++)  r[i] = a[i ^ int'(b[5:0])];
      return r;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic op, logic nar, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] c, logic [7:0] t);
      @(posedge clk);
      op_sel = op; narrow = nar; opnd_a = a; opnd_b = b; opnd_c = c; truth_tbl = t;
      @(negedge clk);
   endtask

   logic [W-1:0] pats [4];
   logic [W-1:0] rev;

   initial begin
      pats[0] = 64'h0123_4567_89AB_CDEF;
      pats[1] = 64'hF0E1_D2C3_B4A5_9687;
      pats[2] = 64'h8000_0000_0000_0001;
      pats[3] = 64'h5A5A_C3C3_0FF0_1234;

      drive(1'b0, 1'b0, '0, '0, '0, 8'h00);
      chk("R1 idle", result, '0);
      chk("R6 idle", {63'd0, carry_out}, '0);

      // R1 R2 R9: every truth table, several operand sets, both narrow settings
      for (int t = 0; t < 256; t++) begin
         for (int p = 0; p < 3; p++) begin
            logic nar = logic'((t + p) % 2);
            drive(1'b0, nar, pats[p], pats[p+1], pats[(p+2)%4], 8'(t));
            chk(nar ? "R9 ternary narrow" : "R1 R2 ternary", result,
                exp_tern(pats[p], pats[p+1], pats[(p+2)%4], 8'(t)));
            chk("R6 ternary", {63'd0, carry_out}, '0);
         end
      end

      // R3 R4 R5 R7 R10: every control value in both modes
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 64; k++) begin
            for (int p = 0; p < 4; p++) begin
               logic [W-1:0] b = {pats[(p+1)%4][63:6], 6'(k)};
               drive(1'b1, logic'(m), pats[p], b, pats[(p+3)%4], 8'(k * 37 + p));
               chk(m ? "R4 narrow permute" : "R3 R2 R7 R10 wide permute",
                   result, exp_perm(pats[p], b, logic'(m)));
               if (m == 1) chk("R5 upper zero", {32'd0, result[63:32]}, '0);
               chk("R6 permute", {63'd0, carry_out}, '0);
            end
         end
      end

      // R8: identity and full reversal
      for (int p = 0; p < 4; p++) begin
         drive(1'b1, 1'b0, pats[p], 64'h0, '0, 8'hFF);
         chk("R8 identity", result, pats[p]);
         for (int i = 0; i < W; i++) rev[i] = pats[p][W-1-i];
         drive(1'b1, 1'b0, pats[p], 64'h3F, '0, 8'h00);
         chk("R8 full reverse", result, rev);
      end

      // R7: truth table change alone does not move a permute result
      drive(1'b1, 1'b0, pats[3], 64'h15, '0, 8'h00);
      rev = result;
      drive(1'b1, 1'b0, pats[3], 64'h15, '0, 8'hA7);
      chk("R7 table ignored", result, rev);

      // R4: upper source half and control bit 5 ignored in narrow mode
      drive(1'b1, 1'b1, 64'h0000_0000_DEAD_BEEF, 64'h0B, '0, 8'h00);
      rev = result;
      drive(1'b1, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF, 64'h2B, '0, 8'h00);
      chk("R4 narrow ignores upper", result, rev);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule